// File: doc/BRIEF.md
# Tree-Structured Unsigned Magnitude Comparator

This block compares two unsigned operands of a parameterized width and reports exactly one of three outcomes: the first operand is smaller, larger, or equal to the second. Each operand is cut into 2-bit slices. Every slice pair goes to a leaf cell that produces a "greater" flag and a "less" flag. Each higher level of a binary tree then merges pairs of flag pairs with the same 2-bit cell. The merge works because a (greater, less) pair read as a 2-bit number ranks the same way as the sub-operands it summarises. The number of cell levels therefore grows with the logarithm of the width, not with the width itself.

Inside the cell, the two terms of each flag are combined with exclusive-or rather than inclusive-or. This is safe because the two terms can never be true at the same time. Every term is built from one primitive of the form `(a & ~b) ^ c`. When the width is not a power of two, the operands are zero-extended at the top.

A parameter can add a register bank after every tree level. Results then emerge a fixed number of cycles after the inputs, one new comparison per clock, with a valid flag carried alongside the data. With the parameter cleared, the tree is purely combinational. The final flag pair drives a small output stage that decodes equality as "neither flag set".

Top module: `cmp_tree_top`

## Requirements
- R1: `lt` is 1 exactly when `opa < opb` as unsigned numbers, for every result marked by `out_valid`.
- R2: `gt` is 1 exactly when `opa > opb` as unsigned numbers, for every result marked by `out_valid`.
- R3: `eq` is 1 exactly when `opa == opb`, for every result marked by `out_valid`.
- R4: Whenever `out_valid` is 1, exactly one of `lt`, `gt` and `eq` is 1.
- R5: With `PIPE=1`, the latency is L = ceil(log2(P/2)) + 1 cycles, where P is the padded width (the smallest power of two that is at least 2 and at least `WIDTH`). The result for operands presented with `in_valid` at clock edge k appears after edge k+L-1 and is marked by `out_valid`. `out_valid` equals `in_valid` delayed by L cycles, including cycles where `in_valid` is 0.
- R6: With `PIPE=0`, the outputs follow the operands in the same cycle, and `out_valid` equals `in_valid`.
- R7: A `WIDTH` that is not a power of two gives correct unsigned results, because the operands are treated as zero-extended to P bits.
- R8: While `rst_n` is 0, `out_valid` is 0 in the pipelined configuration. It stays 0 after reset release until a valid input has propagated.
- R9: With `PIPE=1`, a new operand pair can be accepted every cycle. The results come out in input order, with no gaps beyond those present at the input.
- R10: The most significant differing bit decides the result. Examples: a difference only in the top bit, a difference only in bit 0, and a larger upper half with a smaller lower half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the pipeline registers |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released synchronously inside the block |
| in_valid | input | 1 | Marks the operand pair as a request |
| opa | input | WIDTH | First unsigned operand |
| opb | input | WIDTH | Second unsigned operand |
| out_valid | output | 1 | Marks the result flags as belonging to a request |
| lt | output | 1 | opa is smaller than opb |
| gt | output | 1 | opa is larger than opb |
| eq | output | 1 | opa equals opb |

## Verification
The bound checker keeps its own delay line of reference outcomes. That delay line is released by the raw reset, while the design's registers are released two cycles later through the internal synchronizer. The checker therefore assumes that `in_valid` stays low for at least two cycles after `rst_n` rises. The bench idles for several cycles after release before it issues any request, so both views agree. The checker also assumes the operands are free of unknown values whenever `in_valid` is high; the bench always drives defined data, including during bubble cycles. The 8-bit and 6-bit pipelined instances are swept over every operand pair, with bubbles mixed in. The 32-bit combinational instance gets directed boundary pairs followed by random ones, a share of which are forced equal.

// File: rtl/cmp_tree_pkg.sv
package cmp_tree_pkg;

  // Smallest power of two that is >= w and >= 2.
  function automatic int pad_width(input int w);
    int p;
    p = 2;
    while (p < w) p = p * 2;
    return p;
  endfunction

  // Number of cell levels for a padded width: leaf level plus merge levels.
  function automatic int tree_levels(input int w);
    int n;
    int l;
    n = pad_width(w) / 2;
    l = 1;
    while (n > 1) begin
      n = n / 2;
      l = l + 1;
    end
    return l;
  endfunction

endpackage

// File: rtl/cmp_rgate.sv
// Primitive term generator: r = (a & ~b) ^ c.
module cmp_rgate (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic r
);
  assign r = (a & ~b) ^ c;
endmodule

// File: rtl/cmp_cell2.sv
// 2-bit magnitude cell. gt: xa > yb, lt: xa < yb.
// The low-bit term is gated by high-bit equality; the high and low terms
// are mutually exclusive, so they are joined with XOR.
module cmp_cell2 (
  input  logic [1:0] xa,
  input  logic [1:0] yb,
  output logic       gt,
  output logic       lt
);
  logic hi_same;
  logic hi_gt;
  logic hi_lt;
  logic lo_gt_en;
  logic lo_lt_en;

  assign hi_same  = ~(xa[1] ^ yb[1]);
  assign lo_gt_en = hi_same & xa[0];
  assign lo_lt_en = hi_same & yb[0];

  cmp_rgate u_hgt (.a(xa[1]),    .b(yb[1]), .c(1'b0),  .r(hi_gt));
  cmp_rgate u_hlt (.a(yb[1]),    .b(xa[1]), .c(1'b0),  .r(hi_lt));
  cmp_rgate u_lgt (.a(lo_gt_en), .b(yb[0]), .c(hi_gt), .r(gt));
  cmp_rgate u_llt (.a(lo_lt_en), .b(xa[0]), .c(hi_lt), .r(lt));
endmodule

// File: rtl/cmp_rst_sync.sv
// Reset synchronizer: asynchronous assertion, synchronous release.
module cmp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/cmp_level.sv
// One tree level: NODES cells side by side, optionally registered.
// Pair j reads bits {2j+1, 2j}; the higher bit is the more significant side.
module cmp_level #(
  parameter int NODES = 4,
  parameter bit PIPE  = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vld_i,
  input  logic [2*NODES-1:0] x_i,
  input  logic [2*NODES-1:0] y_i,
  output logic               vld_o,
  output logic [NODES-1:0]   gt_o,
  output logic [NODES-1:0]   lt_o
);
  logic [NODES-1:0] gt_c;
  logic [NODES-1:0] lt_c;

  for (genvar j = 0; j < NODES; j++) begin : g_node
    cmp_cell2 u_cell (
      .xa(x_i[2*j+1 -: 2]),
      .yb(y_i[2*j+1 -: 2]),
      .gt(gt_c[j]),
      .lt(lt_c[j])
    );
  end

  if (PIPE) begin : g_reg
    logic             vld_q;
    logic             vld_d;
    logic [NODES-1:0] gt_q;
    logic [NODES-1:0] lt_q;
    logic [NODES-1:0] gt_d;
    logic [NODES-1:0] lt_d;
    logic             ld_en;

    always_comb begin
      vld_d = vld_i;
      ld_en = vld_i;
      gt_d  = gt_c;
      lt_d  = lt_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= 1'b0;
      else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
      if (ld_en) begin
        gt_q <= gt_d;
        lt_q <= lt_d;
      end
    end

    assign vld_o = vld_q;
    assign gt_o  = gt_q;
    assign lt_o  = lt_q;
  end else begin : g_comb
    assign vld_o = vld_i;
    assign gt_o  = gt_c;
    assign lt_o  = lt_c;
  end
endmodule

// File: rtl/cmp_result.sv
// Output stage: decode the root flag pair into three exclusive signals.
module cmp_result (
  input  logic root_vld,
  input  logic root_gt,
  input  logic root_lt,
  output logic out_valid,
  output logic lt,
  output logic gt,
  output logic eq
);
  assign out_valid = root_vld;
  assign lt        = root_lt;
  assign gt        = root_gt;
  assign eq        = ~(root_gt | root_lt);
endmodule

// File: rtl/cmp_tree_top.sv
module cmp_tree_top
  import cmp_tree_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter bit PIPE  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic             out_valid,
  output logic             lt,
  output logic             gt,
  output logic             eq
);
  localparam int PADW   = pad_width(WIDTH);
  localparam int LEVELS = tree_levels(WIDTH);

  logic            rst_n_int;
  logic [PADW-1:0] opa_pad;
  logic [PADW-1:0] opb_pad;

  cmp_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int));

  assign opa_pad = PADW'(opa);
  assign opb_pad = PADW'(opb);

  for (genvar s = 0; s < LEVELS; s++) begin : g_lvl
    localparam int NODES = PADW >> (s + 1);
    logic [2*NODES-1:0] xin;
    logic [2*NODES-1:0] yin;
    logic               vin;
    logic [NODES-1:0]   gto;
    logic [NODES-1:0]   lto;
    logic               vo;

    if (s == 0) begin : g_leaf
      assign xin = opa_pad;
      assign yin = opb_pad;
      assign vin = in_valid;
    end else begin : g_merge
      // Child flags as 2-bit numbers: greater flags form x, less flags form y.
      assign xin = g_lvl[s-1].gto;
      assign yin = g_lvl[s-1].lto;
      assign vin = g_lvl[s-1].vo;
    end

    cmp_level #(.NODES(NODES), .PIPE(PIPE)) u_lvl (
      .clk  (clk),
      .rst_n(rst_n_int),
      .vld_i(vin),
      .x_i  (xin),
      .y_i  (yin),
      .vld_o(vo),
      .gt_o (gto),
      .lt_o (lto)
    );
  end

  cmp_result u_res (
    .root_vld (g_lvl[LEVELS-1].vo),
    .root_gt  (g_lvl[LEVELS-1].gto[0]),
    .root_lt  (g_lvl[LEVELS-1].lto[0]),
    .out_valid(out_valid),
    .lt       (lt),
    .gt       (gt),
    .eq       (eq)
  );
endmodule

// File: rtl/cmp_tree_chk.sv
module cmp_tree_chk
  import cmp_tree_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter bit PIPE  = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic             out_valid,
  input logic             lt,
  input logic             gt,
  input logic             eq
);
  localparam int LAT = tree_levels(WIDTH);

  // R4
  onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones({lt, gt, eq}) == 1));

  if (PIPE) begin : g_seq
    // Reference delay line: {valid, less, greater, equal}
    logic [3:0] ref_q [LAT];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < LAT; i++) ref_q[i] <= 4'b0;
      end else begin
        ref_q[0] <= {in_valid, opa < opb, opa > opb, opa == opb};
        for (int i = 1; i < LAT; i++) ref_q[i] <= ref_q[i-1];
      end
    end

    // R5
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == ref_q[LAT-1][3]);
    // R1
    less_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (lt == ref_q[LAT-1][2]));
    // R2
    greater_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (gt == ref_q[LAT-1][1]));
    // R3
    equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (eq == ref_q[LAT-1][0]));
  end else begin : g_comb
    // R6
    valid_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == in_valid);
    // R1
    less_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (lt == (opa < opb)));
    // R2
    greater_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (gt == (opa > opb)));
    // R3
    equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (eq == (opa == opb)));
  end
endmodule

bind cmp_tree_top cmp_tree_chk #(.WIDTH(WIDTH), .PIPE(PIPE)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa(opa), .opb(opb),
  .out_valid(out_valid), .lt(lt), .gt(gt), .eq(eq)
);

// File: tb/sim_cmp_tree_top.sv
`timescale 1ns/1ps
module sim_cmp_tree_top;
  // Latency per R5: ceil(log2(P/2)) + 1, P = padded width (8 for both 8 and 6).
  localparam int LAT8 = 3;
  localparam int LAT6 = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // u0: 8-bit pipelined
  logic       v8 = 1'b0;
  logic [7:0] a8 = '0, b8 = '0;
  logic       ov8, lt8, gt8, eq8;
  cmp_tree_top #(.WIDTH(8), .PIPE(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(v8), .opa(a8), .opb(b8),
    .out_valid(ov8), .lt(lt8), .gt(gt8), .eq(eq8));

  // u1: 32-bit combinational
  logic        v32 = 1'b0;
  logic [31:0] a32 = '0, b32 = '0;
  logic        ov32, lt32, gt32, eq32;
  cmp_tree_top #(.WIDTH(32), .PIPE(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(v32), .opa(a32), .opb(b32),
    .out_valid(ov32), .lt(lt32), .gt(gt32), .eq(eq32));

  // u2: 6-bit pipelined (zero-extension)
  logic       v6 = 1'b0;
  logic [5:0] a6 = '0, b6 = '0;
  logic       ov6, lt6, gt6, eq6;
  cmp_tree_top #(.WIDTH(6), .PIPE(1'b1)) u2 (
    .clk(clk), .rst_n(rst_n), .in_valid(v6), .opa(a6), .opb(b6),
    .out_valid(ov6), .lt(lt6), .gt(gt6), .eq(eq6));

  logic [3:0] q8 [LAT8];
  logic [3:0] q6 [LAT6];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_flags(input string tag, input logic [3:0] e,
                             input logic l, input logic g, input logic q);
    chk({tag, " R1 lt"}, 32'(l), 32'(e[2]));
    chk({tag, " R2 gt"}, 32'(g), 32'(e[1]));
    chk({tag, " R3 eq"}, 32'(q), 32'(e[0]));
    chk({tag, " R4 onehot"}, 32'($countones({l, g, q})), 32'd1);
  endtask

  // Called at a negedge: check output, shift expectation, drive new input.
  task automatic step8(input logic v, input logic [7:0] a, input logic [7:0] b);
    chk("R5/R9 u0 out_valid", 32'(ov8), 32'(q8[LAT8-1][3]));
    if (q8[LAT8-1][3]) check_flags("u0", q8[LAT8-1], lt8, gt8, eq8);
    for (int i = LAT8-1; i > 0; i--) q8[i] = q8[i-1];
    q8[0] = {v, a < b, a > b, a == b};
    v8 = v; a8 = a; b8 = b;
  endtask

  task automatic step6(input logic v, input logic [5:0] a, input logic [5:0] b);
    chk("R5/R7 u2 out_valid", 32'(ov6), 32'(q6[LAT6-1][3]));
    if (q6[LAT6-1][3]) check_flags("u2 R7", q6[LAT6-1], lt6, gt6, eq6);
    for (int i = LAT6-1; i > 0; i--) q6[i] = q6[i-1];
    q6[0] = {v, a < b, a > b, a == b};
    v6 = v; a6 = a; b6 = b;
  endtask

  task automatic try32(input logic [31:0] a, input logic [31:0] b, input string tag);
    @(negedge clk);
    v32 = 1'b1; a32 = a; b32 = b;
    #1;
    chk({tag, " R6 out_valid"}, 32'(ov32), 32'd1);
    check_flags({tag, " R6"}, {1'b1, a < b, a > b, a == b}, lt32, gt32, eq32);
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 190000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    for (int i = 0; i < LAT8; i++) q8[i] = 4'b0;
    for (int i = 0; i < LAT6; i++) q6[i] = 4'b0;
    // R8: reset state
    repeat (3) @(negedge clk);
    chk("R8 u0 out_valid in reset", 32'(ov8), 32'd0);
    chk("R8 u2 out_valid in reset", 32'(ov6), 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R8 u0 out_valid idle after reset", 32'(ov8), 32'd0);
    chk("R8 u2 out_valid idle after reset", 32'(ov6), 32'd0);
    // R6: combinational valid passthrough with in_valid low
    #1;
    chk("R6 u1 out_valid idle", 32'(ov32), 32'd0);

    // u0: exhaustive 8-bit, back-to-back with occasional bubbles (R9, R5)
    for (int i = 0; i < 65536; i++) begin
      if ((i % 29) == 7) begin
        @(negedge clk);
        step8(1'b0, 8'($urandom), 8'($urandom));
      end
      @(negedge clk);
      step8(1'b1, i[15:8], i[7:0]);
    end
    for (int i = 0; i < LAT8 + 2; i++) begin
      @(negedge clk);
      step8(1'b0, 8'h00, 8'h00);
    end

    // u2: exhaustive 6-bit (R7)
    for (int i = 0; i < 4096; i++) begin
      if ((i % 13) == 5) begin
        @(negedge clk);
        step6(1'b0, 6'($urandom), 6'($urandom));
      end
      @(negedge clk);
      step6(1'b1, i[11:6], i[5:0]);
    end
    for (int i = 0; i < LAT6 + 2; i++) begin
      @(negedge clk);
      step6(1'b0, 6'h00, 6'h00);
    end

    // u1: directed boundaries (R10) then random
    try32(32'h0, 32'h0, "zero pair");
    try32(32'hFFFF_FFFF, 32'hFFFF_FFFF, "max pair");
    try32(32'h0, 32'hFFFF_FFFF, "min vs max");
    try32(32'hFFFF_FFFF, 32'h0, "max vs min");
    try32(32'h8000_0000, 32'h7FFF_FFFF, "R10 top bit");
    try32(32'h0000_0001, 32'h0000_0000, "R10 bit0");
    try32(32'hFFFF_0000, 32'hFFFF_0001, "R10 low bit under equal top");
    try32(32'h0001_0000, 32'h0000_FFFF, "R10 upper beats lower");
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = ((i % 5) == 0) ? ra : $urandom;
      try32(ra, rb, "random");
    end
    @(negedge clk);
    v32 = 1'b0;
    #1;
    chk("R6 u1 out_valid drop", 32'(ov32), 32'd0);
    report();
  end
endmodule